// File: doc/BRIEF.md
# Real-Time Clock Alarm Comparator

This block watches the running time of a real-time clock and raises an alarm when that time reaches a programmed setting. There are five alarm bytes, all in BCD: hundredths of a second, seconds, minutes, hours, and day/date. The surrounding timekeeping logic presents the current time on the input buses. It pulses `tick` once for every update of the hundredths counter. The comparison is made only on that pulse, so each matching time yields exactly one flag-set event.

Each alarm byte except the hundredths one carries a mask in bit 7. Setting the mask drops that field from the comparison, which is how the alarm is made to repeat every second, minute, hour, day or date. The hundredths byte has no mask bit. Instead, a high nibble of F ignores the tens digit, and the value FF ignores both digits. Bit 6 of the day/date byte chooses whether the stored value is matched against the day of the week or the date of the month.

A match sets a sticky flag. The active-low interrupt output follows the flag when both enables allow it. While the clock runs from its backup supply, the interrupt also needs a separate backup enable. The flag is cleared by writing 0 to the status register.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset, `alarm_flag` is 0 and `int_n` is 1. All five alarm bytes and all control bits are 0, so an all-zero time with a date of 00 matches on a tick.
- R2: When no field is masked, a tick sets the flag only if all five fields equal their alarm bytes. The hundredths, seconds, minutes and hours fields use the address map 0 = hundredths, 1 = seconds, 2 = minutes, 3 = hours, 4 = day/date. Seconds, minutes and hours compare bits 6:0.
- R3: Bit 7 set in alarm byte 1, 2, 3 or 4 removes that field from the comparison.
- R4: In alarm byte 4, bit 6 = 0 compares bits 5:0 with `cur_mday[5:0]`, and bit 6 = 1 compares them with `cur_wday[5:0]`.
- R5: A hundredths alarm byte of 0xF0 to 0xF9 matches on the ones digit only. 0xFF matches any hundredths value. Any other value must equal all 8 bits of `cur_hsec`.
- R6: The flag is set only by a match in a cycle where `tick` is 1. A match without `tick` has no effect. Once set, the flag stays 1 until it is cleared.
- R7: A write to address 6 with data bit 0 = 0 clears the flag one cycle later, and a write with bit 0 = 1 leaves it unchanged. If a tick with a match occurs in the same cycle as the clear, the flag stays 1.
- R8: Address 5 holds the control bits: bit 0 is the alarm-interrupt enable, bit 1 is the interrupt-control bit, and bit 2 is the backup interrupt enable. `int_n` is 0 exactly when the flag, bit 0 and bit 1 are all 1, and either `on_backup` is 0 or bit 2 is 1. `int_n` returns to 1 in the cycle after any of these terms drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Hundredths update strobe from the timekeeper |
| cur_hsec | input | 8 | Current hundredths, BCD |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD |
| cur_wday | input | 8 | Current day of week, BCD |
| cur_mday | input | 8 | Current date of month, BCD |
| on_backup | input | 1 | High while running from the backup supply |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0-4 alarm, 5 control, 6 status) |
| wr_data | input | 8 | Register write data |
| alarm_flag | output | 1 | Sticky alarm flag |
| int_n | output | 1 | Active-low alarm interrupt |

## Verification
The bench goes after the cases where a single field or digit decides the outcome:
- **One field off by one.** The other fields equal their alarm bytes, so a comparator that skips a field would raise a false alarm.
- **Hundredths codes.** The codes F5 and FF are applied; a design that treats F as a literal digit would never fire on them.
- **Day/date selector.** Its two settings are checked against conflicting day and date inputs, which exposes a swapped multiplexer.
- **Match during a clear.** A clear and a matching tick are applied in the same cycle; a design that gives the clear priority would lose an alarm.
- **Match without a tick.** A matching time is held with no tick, which catches a level-sensitive flag.
- **Backup gating of the interrupt.** This catches an interrupt that ignores the supply state.

Randomized alarm settings and times, biased toward equality, then cover mixed mask patterns against a bench-side model.

// File: rtl/rtc_alarm_pkg.sv
// Shared constants and register addresses for the RTC alarm comparator.
// Assumes byte-wide BCD fields and a small register address space.
package rtc_alarm_pkg;
    parameter int BYTE_W   = 8;
    parameter int ADDR_W   = 3;
    parameter int NUM_ALM  = 5;

    typedef enum logic [ADDR_W-1:0] {
        REG_HSEC = 3'd0,
        REG_SEC  = 3'd1,
        REG_MIN  = 3'd2,
        REG_HOUR = 3'd3,
        REG_DAY  = 3'd4,
        REG_CTRL = 3'd5,
        REG_STAT = 3'd6
    } reg_addr_e;

    // comparator flavours picked per field
    typedef enum int {
        CMP_PLAIN = 0,
        CMP_HSEC  = 1,
        CMP_DAY   = 2
    } cmp_kind_e;

    typedef struct packed {
        logic bbie;
        logic intc;
        logic aie;
    } ctrl_t;
endpackage

// File: rtl/rtc_alarm_field_cmp.sv
// One alarm field comparator. KIND selects the variant:
//   plain      - bit 7 masks, bits 6:0 compared
//   hundredths - F in high nibble masks tens digit, FF masks both
//   day/date   - bit 7 masks, bit 6 picks weekday (1) or date (0), bits 5:0 compared
// Assumes inputs are stable BCD during the strobe cycle.
module rtc_alarm_field_cmp
    import rtc_alarm_pkg::*;
#(
    parameter cmp_kind_e KIND = CMP_PLAIN,
    parameter int        W    = BYTE_W
) (
    input  logic [W-1:0] alarm_val,
    input  logic [W-1:0] cur_val,
    input  logic [W-1:0] alt_val,
    output logic         hit
);
    localparam int HALF = W / 2;

    generate
        if (KIND == CMP_HSEC) begin : g_hsec
            logic tens_dc;
            logic ones_dc;
            // don't-care decode of the hundredths special codes
            always_comb begin
                tens_dc = &alarm_val[W-1:HALF];
                ones_dc = tens_dc && (&alarm_val[HALF-1:0]);
                hit = (tens_dc || (alarm_val[W-1:HALF] == cur_val[W-1:HALF]))
                   && (ones_dc || (alarm_val[HALF-1:0] == cur_val[HALF-1:0]));
            end
        end else if (KIND == CMP_DAY) begin : g_day
            logic [W-3:0] pick;
            // choose weekday or date source, then compare unless masked
            always_comb begin
                pick = alarm_val[W-2] ? alt_val[W-3:0] : cur_val[W-3:0];
                hit  = alarm_val[W-1] || (alarm_val[W-3:0] == pick);
            end
        end else begin : g_plain
            // masked field or seven-bit value equality
            always_comb hit = alarm_val[W-1] || (alarm_val[W-2:0] == cur_val[W-2:0]);
        end
    endgenerate
endmodule

// File: rtl/rtc_alarm_regs.sv
// Alarm byte and control register storage, loaded from the write port.
// Assumes one write per cycle; status writes are handled by the flag logic.
module rtc_alarm_regs
    import rtc_alarm_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [BYTE_W-1:0]             wr_data,
    output logic [NUM_ALM-1:0][BYTE_W-1:0] alm,
    output ctrl_t                         ctrl
);
    // alarm bytes: one register per field
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alm <= '0;
        end else if (wr_en && (wr_addr < ADDR_W'(NUM_ALM))) begin
            alm[wr_addr] <= wr_data;
        end
    end

    // control enables
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr_en && (wr_addr == REG_CTRL)) begin
            ctrl <= ctrl_t'(wr_data[2:0]);
        end
    end
endmodule

// File: rtl/rtc_alarm_flag.sv
// Sticky alarm flag and gated active-low interrupt.
// Assumes hit is valid only when tick is high; set beats clear.
module rtc_alarm_flag
    import rtc_alarm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic hit,
    input  logic clr,
    input  ctrl_t ctrl,
    input  logic on_backup,
    output logic flag,
    output logic int_n
);
    // set on strobed match, else clear on request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (tick && hit) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

    // interrupt gating by enables and supply state
    always_comb int_n = !(flag && ctrl.aie && ctrl.intc && (!on_backup || ctrl.bbie));
endmodule

// File: rtl/rtc_alarm_match.sv
// Top: RTC alarm comparator. Holds the alarm bytes, compares them with the
// current BCD time on every hundredths strobe and raises a sticky flag and
// an active-low interrupt. Assumes the current-time inputs carry the freshly
// updated value in the cycle tick is high.
module rtc_alarm_match
    import rtc_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [BYTE_W-1:0] cur_hsec,
    input  logic [BYTE_W-1:0] cur_sec,
    input  logic [BYTE_W-1:0] cur_min,
    input  logic [BYTE_W-1:0] cur_hour,
    input  logic [BYTE_W-1:0] cur_wday,
    input  logic [BYTE_W-1:0] cur_mday,
    input  logic              on_backup,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              alarm_flag,
    output logic              int_n
);
    logic [NUM_ALM-1:0][BYTE_W-1:0] alm;
    logic [NUM_ALM-1:0][BYTE_W-1:0] cur;
    logic [NUM_ALM-1:0]             field_hit;
    ctrl_t                          ctrl;
    logic                           hit_all;
    logic                           clr;

    // gather current time into field order
    always_comb begin
        cur[REG_HSEC] = cur_hsec;
        cur[REG_SEC]  = cur_sec;
        cur[REG_MIN]  = cur_min;
        cur[REG_HOUR] = cur_hour;
        cur[REG_DAY]  = cur_mday;
    end

    rtc_alarm_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .alm     (alm),
        .ctrl    (ctrl)
    );

    for (genvar i = 0; i < NUM_ALM; i++) begin : g_cmp
        localparam cmp_kind_e K = (i == int'(REG_HSEC)) ? CMP_HSEC :
                                  (i == int'(REG_DAY))  ? CMP_DAY  : CMP_PLAIN;
        rtc_alarm_field_cmp #(.KIND(K), .W(BYTE_W)) u_cmp (
            .alarm_val (alm[i]),
            .cur_val   (cur[i]),
            .alt_val   (cur_wday),
            .hit       (field_hit[i])
        );
    end

    // full match and status clear decode
    always_comb begin
        hit_all = &field_hit;
        clr     = wr_en && (wr_addr == REG_STAT) && !wr_data[0];
    end

    rtc_alarm_flag u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .hit       (hit_all),
        .clr       (clr),
        .ctrl      (ctrl),
        .on_backup (on_backup),
        .flag      (alarm_flag),
        .int_n     (int_n)
    );
endmodule

// File: rtl/rtc_alarm_chk.sv
// Assertion checker for rtc_alarm_match, attached by bind.
module rtc_alarm_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       hit,
    input logic       wr_en,
    input logic [2:0] wr_addr,
    input logic [7:0] wr_data,
    input logic       alarm_flag,
    input logic       int_n
);
    AST_FLAG_SET_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flag) |-> $past(tick)); // R6
    AST_FLAG_SET_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flag) |-> $past(hit)); // R2
    AST_FLAG_FALL_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alarm_flag) |-> $past(wr_en && wr_addr == 3'd6 && !wr_data[0])); // R7
    AST_MATCH_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && hit) |=> alarm_flag); // R7
    AST_INT_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !int_n |-> alarm_flag); // R8
endmodule

bind rtc_alarm_match rtc_alarm_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .hit        (hit_all),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .alarm_flag (alarm_flag),
    .int_n      (int_n)
);

// File: tb/test_rtc_alarm_match.sv
`timescale 1ns/1ps
module test_rtc_alarm_match;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] cur_hsec = '0, cur_sec = '0, cur_min = '0, cur_hour = '0;
    logic [7:0] cur_wday = '0, cur_mday = '0;
    logic       on_backup = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       alarm_flag, int_n;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    // bench model
    logic [7:0] m_alm [5];
    logic [2:0] m_ctrl;
    logic       m_flag;

    rtc_alarm_match i_rtc_alarm_match (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cur_hsec(cur_hsec), .cur_sec(cur_sec), .cur_min(cur_min),
        .cur_hour(cur_hour), .cur_wday(cur_wday), .cur_mday(cur_mday),
        .on_backup(on_backup), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .alarm_flag(alarm_flag), .int_n(int_n)
    );

    always #2 clk = ~clk;

    function automatic bit f_plain(input logic [7:0] a, input logic [7:0] c);
        return a[7] || (a[6:0] == c[6:0]);
    endfunction

    function automatic bit f_hsec(input logic [7:0] a, input logic [7:0] c);
        if (a == 8'hFF) return 1'b1;
        if (a[7:4] == 4'hF) return a[3:0] == c[3:0];
        return a == c;
    endfunction

    function automatic bit f_day(input logic [7:0] a, input logic [7:0] wd, input logic [7:0] md);
        if (a[7]) return 1'b1;
        return a[6] ? (a[5:0] == wd[5:0]) : (a[5:0] == md[5:0]);
    endfunction

    function automatic bit f_match();
        return f_hsec(m_alm[0], cur_hsec) && f_plain(m_alm[1], cur_sec)
            && f_plain(m_alm[2], cur_min) && f_plain(m_alm[3], cur_hour)
            && f_day(m_alm[4], cur_wday, cur_mday);
    endfunction

    function automatic bit f_int();
        return !(m_flag && m_ctrl[0] && m_ctrl[1] && (!on_backup || m_ctrl[2]));
    endfunction

    function automatic logic [7:0] rbcd(input int lim);
        int v = $urandom_range(lim);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    task automatic check(input bit ok, input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // one clock: drive at negedge, update model at edge, compare after edge
    task automatic cyc(input logic tk, input logic we, input logic [2:0] wa, input logic [7:0] wd, input string req);
        bit hit;
        @(negedge clk);
        tick = tk; wr_en = we; wr_addr = wa; wr_data = wd;
        @(posedge clk);
        hit = tk && f_match();
        if (hit) m_flag = 1'b1;
        else if (we && wa == 3'd6 && !wd[0]) m_flag = 1'b0;
        if (we && wa < 3'd5) m_alm[wa] = wd;
        if (we && wa == 3'd5) m_ctrl = wd[2:0];
        #1;
        check(alarm_flag === m_flag, req, "alarm_flag", {7'd0, alarm_flag}, {7'd0, m_flag});
        check(int_n === f_int(), req, "int_n", {7'd0, int_n}, {7'd0, f_int()});
        tick = 1'b0; wr_en = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d, input string req);
        cyc(1'b0, 1'b1, a, d, req);
    endtask

    task automatic set_time(input logic [7:0] h, s, mi, hr, wd, md);
        cur_hsec = h; cur_sec = s; cur_min = mi; cur_hour = hr; cur_wday = wd; cur_mday = md;
    endtask

    task automatic set_alarm(input logic [7:0] h, s, mi, hr, dd, input string req);
        wr(3'd0, h, req); wr(3'd1, s, req); wr(3'd2, mi, req); wr(3'd3, hr, req); wr(3'd4, dd, req);
    endtask

    task automatic clear(input string req);
        wr(3'd6, 8'h00, req);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 5; i++) m_alm[i] = 8'h00;
        m_ctrl = 3'b000;
        m_flag = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check(alarm_flag === 1'b0, "R1", "reset flag", {7'd0, alarm_flag}, 8'h00);
        check(int_n === 1'b1, "R1", "reset int_n", {7'd0, int_n}, 8'h01);
        @(negedge clk); rst_n = 1'b1;

        // R1: zero alarm bytes match an all-zero time
        set_time(8'h00, 8'h00, 8'h00, 8'h00, 8'h03, 8'h00);
        cyc(1'b1, 1'b0, 3'd0, 8'h00, "R1");
        check(alarm_flag === 1'b1, "R1", "zero-time match", {7'd0, alarm_flag}, 8'h01);
        clear("R7");

        // R2: full match vs one field off
        set_alarm(8'h78, 8'h56, 8'h34, 8'h12, 8'h15, "R2");
        set_time(8'h78, 8'h56, 8'h35, 8'h12, 8'h02, 8'h15);
        cyc(1'b1, 1'b0, 3'd0, 8'h00, "R2");
        check(alarm_flag === 1'b0, "R2", "minute off", {7'd0, alarm_flag}, 8'h00);
        set_time(8'h78, 8'h56, 8'h34, 8'h12, 8'h02, 8'h15);
        // R6: match held without tick
        cyc(1'b0, 1'b0, 3'd0, 8'h00, "R6");
        check(alarm_flag === 1'b0, "R6", "no tick", {7'd0, alarm_flag}, 8'h00);
        cyc(1'b1, 1'b0, 3'd0, 8'h00, "R2");
        check(alarm_flag === 1'b1, "R2", "full match", {7'd0, alarm_flag}, 8'h01);
        set_time(8'h11, 8'h11, 8'h11, 8'h11, 8'h01, 8'h01);
        cyc(1'b1, 1'b0, 3'd0, 8'h00, "R6");
        check(alarm_flag === 1'b1, "R6", "sticky", {7'd0, alarm_flag}, 8'h01);
        // R7: write 1 keeps, write 0 clears
        wr(3'd6, 8'h01, "R7");
        check(alarm_flag === 1'b1, "R7", "write one", {7'd0, alarm_flag}, 8'h01);
        clear("R7");
        check(alarm_flag === 1'b0, "R7", "write zero", {7'd0, alarm_flag}, 8'h00);

        // R3: mask minutes and day, minute differs
        set_alarm(8'h78, 8'h56, 8'hB4, 8'h12, 8'h80, "R3");
        set_time(8'h78, 8'h56, 8'h07, 8'h12, 8'h05, 8'h29);
        cyc(1'b1, 1'b0, 3'd0, 8'h00, "R3");
        check(alarm_flag === 1'b1, "R3", "masked fields", {7'd0, alarm_flag}, 8'h01);
        clear("R3");
        set_time(8'h78, 8'h57, 8'h07, 8'h12, 8'h05, 8'h29);
        cyc(1'b1, 1'b0, 3'd0, 8'h00, "R3");
        check(alarm_flag === 1'b0, "R3", "unmasked second off", {7'd0, alarm_flag}, 8'h00);

        // R4: day/date selector with conflicting day and date
        set_alarm(8'hFF, 8'h80, 8'h80, 8'h80, 8'h05, "R4");
        set_time(8'h42, 8'h00, 8'h00, 8'h00, 8'h05, 8'h06);
        cyc(1'b1, 1'b0, 3'd0, 8'h00, "R4");
        check(alarm_flag === 1'b0, "R4", "date select, weekday equal", {7'd0, alarm_flag}, 8'h00);
        wr(3'd4, 8'h45, "R4");
        cyc(1'b1, 1'b0, 3'd0, 8'h00, "R4");
        check(alarm_flag === 1'b1, "R4", "weekday select", {7'd0, alarm_flag}, 8'h01);
        clear("R4");

        // R5: hundredths codes
        set_alarm(8'hF5, 8'h80, 8'h80, 8'h80, 8'h80, "R5");
        set_time(8'h35, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01);
        cyc(1'b1, 1'b0, 3'd0, 8'h00, "R5");
        check(alarm_flag === 1'b1, "R5", "F5 vs 35", {7'd0, alarm_flag}, 8'h01);
        clear("R5");
        cur_hsec = 8'h36;
        cyc(1'b1, 1'b0, 3'd0, 8'h00, "R5");
        check(alarm_flag === 1'b0, "R5", "F5 vs 36", {7'd0, alarm_flag}, 8'h00);
        wr(3'd0, 8'hFF, "R5");
        cyc(1'b1, 1'b0, 3'd0, 8'h00, "R5");
        check(alarm_flag === 1'b1, "R5", "FF any", {7'd0, alarm_flag}, 8'h01);

        // R7: clear in the same cycle as a matching tick
        @(negedge clk); tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd6; wr_data = 8'h00;
        @(posedge clk); #1; tick = 1'b0; wr_en = 1'b0;
        check(alarm_flag === 1'b1, "R7", "match beats clear", {7'd0, alarm_flag}, 8'h01);

        // R8: enable combinations and backup gating
        wr(3'd5, 8'h01, "R8");
        check(int_n === 1'b1, "R8", "aie only", {7'd0, int_n}, 8'h01);
        wr(3'd5, 8'h03, "R8");
        check(int_n === 1'b0, "R8", "both enables", {7'd0, int_n}, 8'h00);
        on_backup = 1'b1;
        cyc(1'b0, 1'b0, 3'd0, 8'h00, "R8");
        check(int_n === 1'b1, "R8", "backup blocked", {7'd0, int_n}, 8'h01);
        wr(3'd5, 8'h07, "R8");
        check(int_n === 1'b0, "R8", "backup allowed", {7'd0, int_n}, 8'h00);
        on_backup = 1'b0;
        clear("R8");
        check(int_n === 1'b1, "R8", "flag cleared", {7'd0, int_n}, 8'h01);

        // random mixed settings checked against the model (R2 R3 R4 R5 R6 R7 R8)
        for (int it = 0; it < 400; it++) begin
            int k = $urandom_range(9);
            if (k == 0) begin
                logic [7:0] a [5];
                a[0] = ($urandom_range(3) == 0) ? 8'hFF : ($urandom_range(2) == 0) ? {4'hF, 4'($urandom_range(9))} : rbcd(99);
                a[1] = rbcd(59) | ($urandom_range(2) == 0 ? 8'h80 : 8'h00);
                a[2] = rbcd(59) | ($urandom_range(2) == 0 ? 8'h80 : 8'h00);
                a[3] = rbcd(23) | ($urandom_range(2) == 0 ? 8'h80 : 8'h00);
                a[4] = ($urandom_range(1) ? (8'h40 | rbcd(6)) : rbcd(31)) | ($urandom_range(2) == 0 ? 8'h80 : 8'h00);
                set_alarm(a[0], a[1], a[2], a[3], a[4], "R3");
            end else if (k == 1) begin
                wr(3'd5, 8'($urandom_range(7)), "R8");
            end else if (k == 2) begin
                cyc(1'b0, 1'b1, 3'd6, 8'($urandom_range(1)), "R7");
            end else begin
                cur_hsec = ($urandom_range(3) != 0) ? {(m_alm[0][7:4] == 4'hF) ? 4'($urandom_range(9)) : m_alm[0][7:4], m_alm[0][3:0]} : rbcd(99);
                if (cur_hsec[3:0] == 4'hF) cur_hsec[3:0] = 4'($urandom_range(9));
                cur_sec  = ($urandom_range(3) != 0) ? {1'b0, m_alm[1][6:0]} : rbcd(59);
                cur_min  = ($urandom_range(3) != 0) ? {1'b0, m_alm[2][6:0]} : rbcd(59);
                cur_hour = ($urandom_range(3) != 0) ? {1'b0, m_alm[3][6:0]} : rbcd(23);
                cur_wday = ($urandom_range(2) != 0) ? {2'b0, m_alm[4][5:0]} : rbcd(6);
                cur_mday = ($urandom_range(2) != 0) ? {2'b0, m_alm[4][5:0]} : rbcd(31);
                on_backup = ($urandom_range(3) == 0);
                cyc(1'($urandom_range(3) != 0), 1'b0, 3'd0, 8'h00, "R2");
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule